// File: doc/BRIEF.md
# Vector Fused Multiply-Add Front End

This block sits ahead of the arithmetic core of a 128-bit vector multiply-add unit. Each operation supplies three source vectors and a 5-bit minor code. The sources are the first factor A, a second source B and the old destination T. The block decodes the minor code into an element format and an operand order, and sets the sign controls the arithmetic core needs. It steers the second factor and the addend to the core. It also screens every active element for the three invalid-operation causes of a fused multiply-add.

The screening results are merged into three flags across the active elements. A per-element mask marks where the core's rounded result must be thrown away and replaced by the default quiet NaN. A prepared base vector is also produced. It holds the old destination in every element the format leaves alone and the default quiet NaN in every replaced element, so the core only overwrites the elements it computes and keeps. All results are registered and appear one clock after the operation is presented.

Top module: `fmaf_front`

## Requirements
- R1: A minor code is legal when bits [3:2] are not 00. The `fmt` output copies bits [3:2]: 01 is one double element, 11 is two double elements and 10 is four single elements. `lane_mask` has one bit per element position, where bit k is element k and element 0 is the most significant slice of the vector. It is 0001 for one double, 0011 for two doubles and 1111 for four singles.
- R2: When minor bit 0 is 0, `mul_b` carries B and `addend` carries T, so the result is A*B+T. When bit 0 is 1, `mul_b` carries T and `addend` carries B, so the result is A*T+B. `mul_a` always carries A.
- R3: `neg_addend` equals minor bit 1 (subtract the addend). `neg_result` equals minor bit 4 (negate the final result). Both set gives the negated subtract form.
- R4: `flag_snan` is set when any operand of an active element (A, the second factor or the addend) is a signaling NaN. A signaling NaN has an all-ones exponent, a nonzero fraction and a clear top fraction bit.
- R5: `flag_imz` is set when an active element multiplies infinity by zero, in either order. That element's `subst_mask` bit is set. Its slice of `result_base` is 0x7FF8000000000000 for doubles or 0x7FC00000 for singles.
- R6: `flag_isi` is set when an active element has no NaN operand and no infinity-times-zero, its product is infinite, its addend is infinite, and the product sign differs from the addend sign after `neg_addend` is applied. Result negation has no effect on this flag.
- R7: Each flag is the OR of that cause over the active elements only. Operands in inactive element positions raise no flag and set no `subst_mask` bit.
- R8: In `result_base`, every slice that is not replaced holds the old T value. This includes the upper 64 bits' partner half left unused by the one-double format.
- R9: `class_upd` is set only for legal one-double operations and is clear for both vector formats.
- R10: A valid operation with an illegal minor code sets `illegal`. It clears all three flags, `subst_mask`, `class_upd`, `neg_addend` and `neg_result`, and drives `fmt` and `lane_mask` to zero.
- R11: All outputs are registered and appear one clock after the input. `out_valid` follows `op_valid` by one cycle. When `op_valid` is low, or during the synchronous reset, all flags, `illegal` and the masks are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| minor | input | 5 | Minor operation code |
| src_a | input | 128 | First factor vector A |
| src_b | input | 128 | Source vector B |
| src_t | input | 128 | Old destination vector T |
| out_valid | output | 1 | Registered operation valid |
| illegal | output | 1 | Minor code not a multiply-add variant |
| fmt | output | 2 | Element format (01 one double, 11 two doubles, 10 four singles) |
| lane_mask | output | 4 | Active element positions |
| mul_a | output | 128 | First factor to the core |
| mul_b | output | 128 | Second factor to the core |
| addend | output | 128 | Addend to the core |
| neg_addend | output | 1 | Negate addend before summing |
| neg_result | output | 1 | Negate the final result |
| class_upd | output | 1 | Result-class update enable |
| flag_snan | output | 1 | Signaling-NaN invalid cause |
| flag_imz | output | 1 | Infinity-times-zero invalid cause |
| flag_isi | output | 1 | Infinity-minus-infinity invalid cause |
| subst_mask | output | 4 | Elements whose result is replaced |
| result_base | output | 128 | Old T with default NaN in replaced elements |

## Verification
Every output, including the flags, masks and routed vectors, is due exactly one rising edge after the operation is presented. No output depends on earlier operations. The bench drives each operation on a falling edge and samples all outputs on the next falling edge, which is half a period after the capturing rising edge. Each scenario task checks only that sampled cycle, so a result that arrives a cycle early or late is reported as a mismatch.

// File: rtl/fmaf_pkg.sv
package fmaf_pkg;

  typedef enum logic [1:0] {
    FMT_NONE = 2'b00,
    FMT_SD   = 2'b01,
    FMT_VS   = 2'b10,
    FMT_VD   = 2'b11
  } fmt_e;

  localparam logic [63:0] QNAN_DP = 64'h7FF8_0000_0000_0000;
  localparam logic [31:0] QNAN_SP = 32'h7FC0_0000;

  typedef struct packed {
    logic legal;
    fmt_e fmt;
    logic m_form;
    logic neg_add;
    logic neg_res;
    logic class_upd;
  } dec_t;

endpackage

// File: rtl/fmaf_decode.sv
module fmaf_decode
  import fmaf_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic [CODE_W-1:0] minor,
  output dec_t              dec
);

  logic legal;

  always_comb begin
    legal         = (minor[3:2] != 2'b00);
    dec.legal     = legal;
    dec.fmt       = legal ? fmt_e'(minor[3:2]) : FMT_NONE;
    dec.m_form    = legal & minor[0];
    dec.neg_add   = legal & minor[1];
    dec.neg_res   = legal & minor[4];
    dec.class_upd = legal & (minor[3:2] == 2'b01);
  end

endmodule

// File: rtl/fmaf_class.sv
module fmaf_class #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic [EXP_W+MAN_W:0] val,
  output logic                 is_nan,
  output logic                 is_snan,
  output logic                 is_inf,
  output logic                 is_zero
);

  localparam int W = 1 + EXP_W + MAN_W;

  logic exp_ones;
  logic man_nz;

  always_comb begin
    exp_ones = &val[W-2:MAN_W];
    man_nz   = |val[MAN_W-1:0];
    is_nan   = exp_ones & man_nz;
    is_snan  = exp_ones & man_nz & ~val[MAN_W-1];
    is_inf   = exp_ones & ~man_nz;
    is_zero  = ~|val[W-2:0];
  end

endmodule

// File: rtl/fmaf_screen.sv
module fmaf_screen #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52
) (
  input  logic [EXP_W+MAN_W:0] fa,
  input  logic [EXP_W+MAN_W:0] fb,
  input  logic [EXP_W+MAN_W:0] fc,
  input  logic                 neg_add,
  output logic                 snan,
  output logic                 imz,
  output logic                 isi
);

  localparam int W = 1 + EXP_W + MAN_W;

  logic a_nan, a_snan, a_inf, a_zero;
  logic b_nan, b_snan, b_inf, b_zero;
  logic c_nan, c_snan, c_inf, c_zero;

  fmaf_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_a (
    .val(fa), .is_nan(a_nan), .is_snan(a_snan), .is_inf(a_inf), .is_zero(a_zero)
  );
  fmaf_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_b (
    .val(fb), .is_nan(b_nan), .is_snan(b_snan), .is_inf(b_inf), .is_zero(b_zero)
  );
  fmaf_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls_c (
    .val(fc), .is_nan(c_nan), .is_snan(c_snan), .is_inf(c_inf), .is_zero(c_zero)
  );

  logic any_nan;
  logic prod_inf;
  logic prod_sign;
  logic add_sign;

  always_comb begin
    snan      = a_snan | b_snan | c_snan;
    imz       = (a_inf & b_zero) | (a_zero & b_inf);
    any_nan   = a_nan | b_nan | c_nan;
    prod_inf  = (a_inf | b_inf) & ~imz & ~any_nan;
    prod_sign = fa[W-1] ^ fb[W-1];
    add_sign  = fc[W-1] ^ neg_add;
    isi       = prod_inf & c_inf & (prod_sign != add_sign);
  end

  logic unused_zero;
  assign unused_zero = c_zero;

endmodule

// File: rtl/fmaf_front.sv
module fmaf_front
  import fmaf_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int CODE_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               op_valid,
  input  logic [CODE_W-1:0]  minor,
  input  logic [VEC_W-1:0]   src_a,
  input  logic [VEC_W-1:0]   src_b,
  input  logic [VEC_W-1:0]   src_t,
  output logic               out_valid,
  output logic               illegal,
  output logic [1:0]         fmt,
  output logic [VEC_W/32-1:0] lane_mask,
  output logic [VEC_W-1:0]   mul_a,
  output logic [VEC_W-1:0]   mul_b,
  output logic [VEC_W-1:0]   addend,
  output logic               neg_addend,
  output logic               neg_result,
  output logic               class_upd,
  output logic               flag_snan,
  output logic               flag_imz,
  output logic               flag_isi,
  output logic [VEC_W/32-1:0] subst_mask,
  output logic [VEC_W-1:0]   result_base
);

  localparam int DP_W = 64;
  localparam int SP_W = 32;
  localparam int NDP  = VEC_W / DP_W;
  localparam int NSP  = VEC_W / SP_W;

  dec_t dec;

  fmaf_decode #(.CODE_W(CODE_W)) u_decode (
    .minor(minor),
    .dec  (dec)
  );

  logic [VEC_W-1:0] mulb_c;
  logic [VEC_W-1:0] add_c;

  always_comb begin
    mulb_c = dec.m_form ? src_t : src_b;
    add_c  = dec.m_form ? src_b : src_t;
  end

  logic [NDP-1:0] dp_snan, dp_imz, dp_isi;
  logic [NSP-1:0] sp_snan, sp_imz, sp_isi;

  for (genvar gi = 0; gi < NDP; gi++) begin : g_dp
    localparam int HI = VEC_W - 1 - DP_W * gi;
    fmaf_screen #(.EXP_W(11), .MAN_W(52)) u_scr (
      .fa     (src_a[HI -: DP_W]),
      .fb     (mulb_c[HI -: DP_W]),
      .fc     (add_c[HI -: DP_W]),
      .neg_add(dec.neg_add),
      .snan   (dp_snan[gi]),
      .imz    (dp_imz[gi]),
      .isi    (dp_isi[gi])
    );
  end

  for (genvar gj = 0; gj < NSP; gj++) begin : g_sp
    localparam int HI = VEC_W - 1 - SP_W * gj;
    fmaf_screen #(.EXP_W(8), .MAN_W(23)) u_scr (
      .fa     (src_a[HI -: SP_W]),
      .fb     (mulb_c[HI -: SP_W]),
      .fc     (add_c[HI -: SP_W]),
      .neg_add(dec.neg_add),
      .snan   (sp_snan[gj]),
      .imz    (sp_imz[gj]),
      .isi    (sp_isi[gj])
    );
  end

  logic [NSP-1:0]   mask_c;
  logic [NDP-1:0]   dp_act;
  logic [NSP-1:0]   sp_act;
  logic [NSP-1:0]   subst_c;
  logic             snan_c, imz_c, isi_c;
  logic [VEC_W-1:0] res_c;
  logic             live;

  always_comb begin
    live   = op_valid & dec.legal;
    mask_c = '0;
    if (live) begin
      case (dec.fmt)
        FMT_SD:  mask_c[0] = 1'b1;
        FMT_VD:  mask_c[NDP-1:0] = '1;
        FMT_VS:  mask_c = '1;
        default: mask_c = '0;
      endcase
    end
    dp_act = (dec.fmt != FMT_VS) ? mask_c[NDP-1:0] : '0;
    sp_act = (dec.fmt == FMT_VS) ? mask_c : '0;

    snan_c = |(dp_snan & dp_act) | |(sp_snan & sp_act);
    imz_c  = |(dp_imz  & dp_act) | |(sp_imz  & sp_act);
    isi_c  = |(dp_isi  & dp_act) | |(sp_isi  & sp_act);

    if (dec.fmt == FMT_VS) subst_c = sp_imz & sp_act;
    else                   subst_c = {{(NSP-NDP){1'b0}}, dp_imz & dp_act};

    res_c = src_t;
    if (dec.fmt == FMT_VS) begin
      for (int k = 0; k < NSP; k++)
        if (subst_c[k]) res_c[VEC_W-1-SP_W*k -: SP_W] = QNAN_SP;
    end else begin
      for (int k = 0; k < NDP; k++)
        if (subst_c[k]) res_c[VEC_W-1-DP_W*k -: DP_W] = QNAN_DP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      illegal     <= 1'b0;
      fmt         <= 2'b00;
      lane_mask   <= '0;
      mul_a       <= '0;
      mul_b       <= '0;
      addend      <= '0;
      neg_addend  <= 1'b0;
      neg_result  <= 1'b0;
      class_upd   <= 1'b0;
      flag_snan   <= 1'b0;
      flag_imz    <= 1'b0;
      flag_isi    <= 1'b0;
      subst_mask  <= '0;
      result_base <= '0;
    end else begin
      out_valid   <= op_valid;
      illegal     <= op_valid & ~dec.legal;
      fmt         <= live ? dec.fmt : FMT_NONE;
      lane_mask   <= mask_c;
      mul_a       <= src_a;
      mul_b       <= mulb_c;
      addend      <= add_c;
      neg_addend  <= live & dec.neg_add;
      neg_result  <= live & dec.neg_res;
      class_upd   <= live & dec.class_upd;
      flag_snan   <= snan_c;
      flag_imz    <= imz_c;
      flag_isi    <= isi_c;
      subst_mask  <= subst_c;
      result_base <= res_c;
    end
  end

  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (rst)
    illegal |-> !(flag_snan || flag_imz || flag_isi || class_upd) && subst_mask == '0); // R10

  AST_SUBST_ACTIVE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (subst_mask & ~lane_mask) == '0); // R7

  AST_CLASS_SCALAR_ONLY: assert property (@(posedge clk) disable iff (rst)
    class_upd |-> fmt == FMT_SD); // R9

  AST_SUBST_HAS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (|subst_mask) |-> flag_imz); // R5

  AST_DP_SUBST_NAN: assert property (@(posedge clk) disable iff (rst)
    (subst_mask[0] && fmt != FMT_VS) |-> result_base[VEC_W-1 -: DP_W] == QNAN_DP); // R5

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> out_valid); // R11

endmodule

// File: tb/test_fmaf_front.sv
module test_fmaf_front;

  localparam logic [63:0] D_ONE  = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] D_TWO  = 64'h4000_0000_0000_0000;
  localparam logic [63:0] D_INF  = 64'h7FF0_0000_0000_0000;
  localparam logic [63:0] D_NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] D_ZERO = 64'h0;
  localparam logic [63:0] D_SNAN = 64'h7FF4_0000_0000_0000;
  localparam logic [63:0] D_QNAN = 64'h7FF8_0000_0000_0000;
  localparam logic [31:0] S_ONE  = 32'h3F80_0000;
  localparam logic [31:0] S_INF  = 32'h7F80_0000;
  localparam logic [31:0] S_ZERO = 32'h0;
  localparam logic [31:0] S_SNAN = 32'h7FA0_0000;
  localparam logic [31:0] S_QNAN = 32'h7FC0_0000;

  logic         clk = 1'b0;
  logic         rst;
  logic         op_valid;
  logic [4:0]   minor;
  logic [127:0] src_a, src_b, src_t;
  logic         out_valid, illegal, neg_addend, neg_result, class_upd;
  logic         flag_snan, flag_imz, flag_isi;
  logic [1:0]   fmt;
  logic [3:0]   lane_mask, subst_mask;
  logic [127:0] mul_a, mul_b, addend, result_base;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  fmaf_front i_fmaf_front (
    .clk(clk), .rst(rst), .op_valid(op_valid), .minor(minor),
    .src_a(src_a), .src_b(src_b), .src_t(src_t),
    .out_valid(out_valid), .illegal(illegal), .fmt(fmt), .lane_mask(lane_mask),
    .mul_a(mul_a), .mul_b(mul_b), .addend(addend),
    .neg_addend(neg_addend), .neg_result(neg_result), .class_upd(class_upd),
    .flag_snan(flag_snan), .flag_imz(flag_imz), .flag_isi(flag_isi),
    .subst_mask(subst_mask), .result_base(result_base)
  );

  task automatic check(input string what, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] m, input logic [127:0] a, input logic [127:0] b,
                       input logic [127:0] t);
    @(negedge clk);
    op_valid = 1'b1; minor = m; src_a = a; src_b = b; src_t = t;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; op_valid = 1'b0; minor = '0; src_a = '0; src_b = '0; src_t = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 reset out_valid", 128'(out_valid), 128'd0);
    check("R11 reset flags", {flag_snan, flag_imz, flag_isi, illegal}, 128'd0);
    check("R11 reset result", result_base, 128'd0);
  endtask

  task automatic t_decode();
    logic [127:0] dv, sv;
    dv = {D_ONE, D_TWO};
    sv = {S_ONE, S_ONE, S_ONE, S_ONE};
    for (int c = 0; c < 32; c++) begin
      logic [4:0] m;
      logic       leg;
      logic [3:0] em;
      m   = 5'(c);
      leg = (m[3:2] != 2'b00);
      em  = !leg ? 4'b0000 : (m[3:2] == 2'b01) ? 4'b0001 : (m[3:2] == 2'b11) ? 4'b0011 : 4'b1111;
      apply(m, (m[3:2] == 2'b10) ? sv : dv, dv, dv);
      check($sformatf("R1 fmt code %h", m), 128'(fmt), leg ? 128'(m[3:2]) : 128'd0);
      check($sformatf("R1 lane_mask code %h", m), 128'(lane_mask), 128'(em));
      check($sformatf("R3 negs code %h", m), {neg_addend, neg_result},
            leg ? 128'({m[1], m[4]}) : 128'd0);
      check($sformatf("R9 class_upd code %h", m), 128'(class_upd), 128'(leg && m[3:2] == 2'b01));
      check($sformatf("R10 illegal code %h", m), 128'(illegal), 128'(!leg));
    end
  endtask

  task automatic t_order();
    logic [127:0] a, b, t;
    a = {D_ONE, D_ONE}; b = {D_TWO, D_ZERO}; t = {D_ZERO, D_TWO};
    apply(5'h04, a, b, t);
    check("R2 A-form mul_b", mul_b, b);
    check("R2 A-form addend", addend, t);
    check("R2 mul_a", mul_a, a);
    apply(5'h05, a, b, t);
    check("R2 M-form mul_b", mul_b, t);
    check("R2 M-form addend", addend, b);
  endtask

  task automatic t_snan();
    logic [127:0] t;
    t = {S_ONE, S_ONE, S_ONE, S_ONE};
    apply(5'h08, t, {S_ONE, S_ONE, S_SNAN, S_ONE}, t);
    check("R4 snan in B lane 2", {flag_snan, flag_imz, flag_isi}, 128'b100);
    check("R4 no subst", 128'(subst_mask), 128'd0);
    check("R8 result keeps T", result_base, t);
    apply(5'h04, {D_ONE, D_ONE}, {D_ONE, D_ONE}, {D_ONE, D_SNAN});
    check("R7 snan in unused half ignored", 128'(flag_snan), 128'd0);
  endtask

  task automatic t_imz();
    logic [127:0] t;
    t = {D_TWO, D_ONE};
    apply(5'h0C, {D_ONE, D_INF}, {D_ONE, D_ZERO}, t);
    check("R5 imz flag", {flag_snan, flag_imz, flag_isi}, 128'b010);
    check("R5 subst lane 1", 128'(subst_mask), 128'b0010);
    check("R5 result lane 1 qnan", result_base, {D_TWO, D_QNAN});
    apply(5'h08, {S_ZERO, S_ONE, S_ONE, S_ONE}, {S_INF, S_ONE, S_ONE, S_ONE},
          {S_ONE, S_ONE, S_ONE, S_ONE});
    check("R5 zero*inf lane 0 subst", 128'(subst_mask), 128'b0001);
    check("R5 single qnan", result_base, {S_QNAN, S_ONE, S_ONE, S_ONE});
    apply(5'h0D, {D_INF, D_ONE}, {D_ONE, D_ONE}, {D_ZERO, D_ONE});
    check("R2 R5 M-form imz via T", {flag_imz, subst_mask}, 128'b1_0001);
  endtask

  task automatic t_isi();
    apply(5'h04, {D_INF, D_ONE}, {D_ONE, D_ONE}, {D_NINF, D_ONE});
    check("R6 inf + -inf", 128'(flag_isi), 128'd1);
    apply(5'h04, {D_INF, D_ONE}, {D_ONE, D_ONE}, {D_INF, D_ONE});
    check("R6 inf + inf no isi", 128'(flag_isi), 128'd0);
    apply(5'h06, {D_INF, D_ONE}, {D_ONE, D_ONE}, {D_INF, D_ONE});
    check("R6 subtract form inf - inf", 128'(flag_isi), 128'd1);
    apply(5'h14, {D_INF, D_ONE}, {D_ONE, D_ONE}, {D_NINF, D_ONE});
    check("R6 result negation irrelevant", 128'(flag_isi), 128'd1);
    apply(5'h04, {D_INF, D_ONE}, {D_ZERO, D_ONE}, {D_NINF, D_ONE});
    check("R6 imz suppresses isi", {flag_imz, flag_isi}, 128'b10);
  endtask

  task automatic t_merge();
    apply(5'h08, {S_SNAN, S_ONE, S_ONE, S_INF}, {S_ONE, S_ONE, S_ONE, S_ZERO},
          {S_ONE, S_ONE, S_ONE, S_ONE});
    check("R7 merged flags", {flag_snan, flag_imz, flag_isi}, 128'b110);
    check("R7 merged subst", 128'(subst_mask), 128'b1000);
    apply(5'h04, {D_ONE, D_INF}, {D_ONE, D_ZERO}, {D_TWO, D_TWO});
    check("R7 imz in unused half ignored", {flag_imz, subst_mask}, 128'd0);
    check("R8 unused half keeps T", result_base, {D_TWO, D_TWO});
  endtask

  task automatic t_illegal();
    apply(5'h10, {D_INF, D_SNAN}, {D_ZERO, D_ONE}, {D_ONE, D_ONE});
    check("R10 illegal set", 128'(illegal), 128'd1);
    check("R10 flags quiet", {flag_snan, flag_imz, flag_isi, class_upd, subst_mask}, 128'd0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    op_valid = 1'b0; minor = 5'h04;
    src_a = {D_INF, D_INF}; src_b = {D_ZERO, D_ZERO};
    @(negedge clk);
    check("R11 idle out_valid", 128'(out_valid), 128'd0);
    check("R11 idle flags", {flag_imz, lane_mask}, 128'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_decode();
    t_order();
    t_snan();
    t_imz();
    t_isi();
    t_merge();
    t_illegal();
    t_idle();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule